// File: doc/BRIEF.md
# Flash Command Mode Controller with Query Table

This block is the command-interface state machine of a byte-wide flash device. It watches qualified write cycles and decides which of three read modes the device is in: normal array read, autoselect, or the query mode that serves a fixed identification table. Each read request returns one byte a cycle later. The byte comes from the external array port, from a fixed autoselect identifier, or from the built-in query table, depending on the current mode.

A host enters query mode by writing the query opcode to the query address. It may do this from array read or from autoselect. It leaves query mode with the reset opcode. The controller records where the query was entered from, so that the reset returns the host to that mode. Autoselect is reached through a three-write unlock sequence. A separate abort input from the write qualifier forces the controller back to array read at any time.

Top module: `flashq_mode_ctrl`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the controller goes to array read (`mode` = 0) and `rd_valid` is 0 after that edge.
- R2: A write of data 98h in array read enters query mode (`mode` = 2) only when the whole write address equals 55h. A 98h write to any other address, even one whose low byte is 55h, leaves the mode unchanged.
- R3: In array read, the write sequence AAh to 555h, then 55h to 2AAh, then 90h to 555h enters autoselect (`mode` = 1). Any write that does not match the next expected cycle abandons the sequence, and the controller stays in array read.
- R4: In autoselect, a write of 98h to address 55h enters query mode.
- R5: Writing F0h to any address in query mode returns to autoselect if query mode was entered from autoselect, and to array read otherwise. Writing F0h in autoselect returns to array read.
- R6: In query mode, every write whose data is not F0h is ignored: the mode stays 2 and table reads are unchanged.
- R7: In query mode, reads of 10h, 11h and 12h return 51h, 52h and 59h. Reads of 13h and 15h return 02h and 40h.
- R8: In query mode, reads of 14h, 16h and 17h through 1Ah return 00h, and so does a read of any address outside 10h to 1Ah.
- R9: A read request raises `rd_valid` for exactly one cycle, one clock after the request. In array read, `rd_data` then holds the `arr_data` value that was present at the request.
- R10: In autoselect, a read of any address returns the parameter `AUTO_ID`.
- R11: When `force_array` is high at a clock edge, the controller is in array read after that edge, whatever the state and whatever write arrives in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| force_array | input | 1 | Abort from the write qualifier; forces array read |
| wr_valid | input | 1 | Accept strobe for a qualified write cycle |
| wr_addr | input | AW | Write address |
| wr_data | input | 8 | Write data (command byte) |
| rd_req | input | 1 | Read request |
| rd_addr | input | AW | Read address |
| arr_data | input | 8 | Byte from the external array for the requested address |
| rd_valid | output | 1 | Read data valid, one cycle after `rd_req` |
| rd_data | output | 8 | Read result |
| mode | output | 2 | Current mode: 0 array read, 1 autoselect, 2 query |

## Verification
The bench builds the controller with `AW` = 12 and `AUTO_ID` = 3Ch. The 12-bit address lets it write the query opcode to 855h, whose low byte matches 55h, and confirm that the full-address decode rejects it. It also reads addresses just outside the table and high in the space. The non-default `AUTO_ID` shows that autoselect reads come from the parameter and not from the array port or the table.

// File: rtl/flashq_pkg.sv
// Package: shared mode and sequencer encodings plus command constants for
// the flash command mode controller. Assumes a byte-wide command bus.
package flashq_pkg;

    localparam int BYTE_W = 8;

    // Externally visible read mode
    typedef enum logic [1:0] {
        MODE_ARRAY = 2'd0,
        MODE_AUTO  = 2'd1,
        MODE_QUERY = 2'd2
    } mode_e;

    // Internal sequencer state; unlock steps read like array mode
    typedef enum logic [2:0] {
        S_ARRAY = 3'd0,
        S_UNL1  = 3'd1,
        S_UNL2  = 3'd2,
        S_AUTO  = 3'd3,
        S_QUERY = 3'd4
    } seq_e;

    localparam logic [BYTE_W-1:0] CMD_RESET   = 8'hF0;
    localparam logic [BYTE_W-1:0] CMD_QUERY   = 8'h98;
    localparam logic [BYTE_W-1:0] CMD_UNL_A   = 8'hAA;
    localparam logic [BYTE_W-1:0] CMD_UNL_B   = 8'h55;
    localparam logic [BYTE_W-1:0] CMD_AUTOSEL = 8'h90;

    localparam int ADDR_QUERY = 'h55;
    localparam int ADDR_UNL_A = 'h555;
    localparam int ADDR_UNL_B = 'h2AA;

endpackage

// File: rtl/flashq_seq.sv
// Module: command sequencer. Decodes qualified writes into mode changes,
// keeps the autoselect unlock progress and remembers where query mode was
// entered from. Assumes AW >= 11 so the unlock addresses fit.
module flashq_seq
    import flashq_pkg::*;
#(
    parameter int AW = 22
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              force_array,
    input  logic              wr_valid,
    input  logic [AW-1:0]     wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    output mode_e             mode
);

    localparam logic [AW-1:0] A_QUERY = AW'(ADDR_QUERY);
    localparam logic [AW-1:0] A_UNL_A = AW'(ADDR_UNL_A);
    localparam logic [AW-1:0] A_UNL_B = AW'(ADDR_UNL_B);

    seq_e state_q, state_n;
    logic from_auto_q, from_auto_n;

    logic hit_query, hit_unl_a, hit_unl_b, hit_autosel, hit_reset;

    // Decode the incoming write against each recognised command cycle
    always_comb begin
        hit_query   = wr_valid && (wr_addr == A_QUERY) && (wr_data == CMD_QUERY);
        hit_unl_a   = wr_valid && (wr_addr == A_UNL_A) && (wr_data == CMD_UNL_A);
        hit_unl_b   = wr_valid && (wr_addr == A_UNL_B) && (wr_data == CMD_UNL_B);
        hit_autosel = wr_valid && (wr_addr == A_UNL_A) && (wr_data == CMD_AUTOSEL);
        hit_reset   = wr_valid && (wr_data == CMD_RESET);
    end

    // Next-state and origin-flag selection
    always_comb begin
        state_n     = state_q;
        from_auto_n = from_auto_q;
        unique case (state_q)
            S_ARRAY: begin
                if (hit_query) begin
                    state_n     = S_QUERY;
                    from_auto_n = 1'b0;
                end else if (hit_unl_a) begin
                    state_n = S_UNL1;
                end
            end
            S_UNL1: begin
                if (wr_valid) state_n = hit_unl_b ? S_UNL2 : S_ARRAY;
            end
            S_UNL2: begin
                if (wr_valid) state_n = hit_autosel ? S_AUTO : S_ARRAY;
            end
            S_AUTO: begin
                if (hit_query) begin
                    state_n     = S_QUERY;
                    from_auto_n = 1'b1;
                end else if (hit_reset) begin
                    state_n = S_ARRAY;
                end
            end
            S_QUERY: begin
                if (hit_reset) state_n = from_auto_q ? S_AUTO : S_ARRAY;
            end
            default: state_n = S_ARRAY;
        endcase
    end

    // State register with synchronous reset and abort override
    always_ff @(posedge clk) begin
        if (!rst_n || force_array) begin
            state_q     <= S_ARRAY;
            from_auto_q <= 1'b0;
        end else begin
            state_q     <= state_n;
            from_auto_q <= from_auto_n;
        end
    end

    // Map the internal state onto the visible mode
    always_comb begin
        unique case (state_q)
            S_AUTO:  mode = MODE_AUTO;
            S_QUERY: mode = MODE_QUERY;
            default: mode = MODE_ARRAY;
        endcase
    end

    AST_ABORT_TO_ARRAY: assert property (@(posedge clk) disable iff (!rst_n)
        force_array |=> (state_q == S_ARRAY)); // R11

    AST_QUERY_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_QUERY && $past(state_q) != S_QUERY) |->
        $past(wr_valid && wr_data == CMD_QUERY && wr_addr == A_QUERY)); // R2

    AST_AUTO_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_AUTO && $past(state_q) != S_AUTO && $past(state_q) != S_QUERY) |->
        $past(state_q == S_UNL2 && wr_data == CMD_AUTOSEL)); // R3

    AST_QUERY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_QUERY && !force_array && !(wr_valid && wr_data == CMD_RESET))
        |=> (state_q == S_QUERY)); // R6

    AST_QUERY_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_QUERY && !force_array && wr_valid && wr_data == CMD_RESET)
        |=> (state_q == ($past(from_auto_q) ? S_AUTO : S_ARRAY))); // R5

endmodule

// File: rtl/flashq_table.sv
// Module: query identification table. Pure combinational lookup; the
// address must be fully decoded, so upper bits must be zero for a hit.
// Assumes AW > 5.
module flashq_table
    import flashq_pkg::*;
#(
    parameter int AW = 22
) (
    input  logic [AW-1:0]     addr,
    output logic [BYTE_W-1:0] data
);

    localparam int LOW_W = 5;
    localparam int HI_W  = AW - LOW_W;

    logic in_window;

    // Window check: only the first 32 addresses can hold table entries
    always_comb in_window = (addr[AW-1:LOW_W] == {HI_W{1'b0}});

    // Table entries; everything unlisted reads zero
    always_comb begin
        data = '0;
        if (in_window) begin
            unique case (addr[LOW_W-1:0])
                5'h10:   data = 8'h51;
                5'h11:   data = 8'h52;
                5'h12:   data = 8'h59;
                5'h13:   data = 8'h02;
                5'h15:   data = 8'h40;
                default: data = '0;
            endcase
        end
    end

endmodule

// File: rtl/flashq_rdpath.sv
// Module: registered read path. Selects array, autoselect or table byte by
// the mode at the request and presents it one cycle later with a valid.
module flashq_rdpath
    import flashq_pkg::*;
#(
    parameter logic [BYTE_W-1:0] AUTO_ID = 8'h01
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_req,
    input  mode_e             mode,
    input  logic [BYTE_W-1:0] arr_data,
    input  logic [BYTE_W-1:0] tbl_data,
    output logic              rd_valid,
    output logic [BYTE_W-1:0] rd_data
);

    logic [BYTE_W-1:0] sel_data;

    // Pick the source byte for the current mode
    always_comb begin
        unique case (mode)
            MODE_AUTO:  sel_data = AUTO_ID;
            MODE_QUERY: sel_data = tbl_data;
            default:    sel_data = arr_data;
        endcase
    end

    // Register the result and its valid flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_req;
            if (rd_req) rd_data <= sel_data;
        end
    end

    AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> rd_valid); // R9

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> !rd_valid); // R9

    AST_ARRAY_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && mode == MODE_ARRAY) |=> (rd_data == $past(arr_data))); // R9

    AST_AUTO_ID: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && mode == MODE_AUTO) |=> (rd_data == AUTO_ID)); // R10

endmodule

// File: rtl/flashq_mode_ctrl.sv
// Module: top of the flash command mode controller. Connects the command
// sequencer, the query table and the registered read path. Assumes writes
// and reads arrive already qualified by the bus interface.
module flashq_mode_ctrl
    import flashq_pkg::*;
#(
    parameter int                AW      = 22,
    parameter logic [BYTE_W-1:0] AUTO_ID = 8'h01
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              force_array,
    input  logic              wr_valid,
    input  logic [AW-1:0]     wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              rd_req,
    input  logic [AW-1:0]     rd_addr,
    input  logic [BYTE_W-1:0] arr_data,
    output logic              rd_valid,
    output logic [BYTE_W-1:0] rd_data,
    output logic [1:0]        mode
);

    mode_e             cur_mode;
    logic [BYTE_W-1:0] tbl_data;

    flashq_seq #(.AW(AW)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .force_array (force_array),
        .wr_valid    (wr_valid),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .mode        (cur_mode)
    );

    flashq_table #(.AW(AW)) u_table (
        .addr (rd_addr),
        .data (tbl_data)
    );

    flashq_rdpath #(.AUTO_ID(AUTO_ID)) u_rdpath (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_req   (rd_req),
        .mode     (cur_mode),
        .arr_data (arr_data),
        .tbl_data (tbl_data),
        .rd_valid (rd_valid),
        .rd_data  (rd_data)
    );

    // Expose the mode as a plain vector
    always_comb mode = cur_mode;

    AST_QRY_STRING: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && cur_mode == MODE_QUERY && rd_addr == AW'('h11)) |=> (rd_data == 8'h52)); // R7

    AST_OUTSIDE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && cur_mode == MODE_QUERY && rd_addr > AW'('h1A)) |=> (rd_data == 8'h00)); // R8

endmodule

// File: tb/flashq_mode_ctrl_tb.sv
`timescale 1ns/1ps
module flashq_mode_ctrl_tb;

    localparam int         AW      = 12;
    localparam logic [7:0] AUTO_ID = 8'h3C;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          force_array = 1'b0;
    logic          wr_valid = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [7:0]    wr_data = '0;
    logic          rd_req = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic [7:0]    arr_data = '0;
    logic          rd_valid;
    logic [7:0]    rd_data;
    logic [1:0]    mode;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #2.5 clk = ~clk;

    flashq_mode_ctrl #(.AW(AW), .AUTO_ID(AUTO_ID)) u_dut (
        .clk(clk), .rst_n(rst_n), .force_array(force_array),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_req(rd_req), .rd_addr(rd_addr), .arr_data(arr_data),
        .rd_valid(rd_valid), .rd_data(rd_data), .mode(mode)
    );

    function automatic logic [7:0] query_byte(input logic [AW-1:0] a);
        case (a)
            12'h010: return 8'h51;
            12'h011: return 8'h52;
            12'h012: return 8'h59;
            12'h013: return 8'h02;
            12'h015: return 8'h40;
            default: return 8'h00;
        endcase
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_valid = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    // Driver: issue a read and push the expected byte for the monitor
    task automatic rd(input logic [AW-1:0] a, input logic [7:0] arr,
                      input logic [7:0] exp, input string tag);
        @(negedge clk);
        rd_req = 1'b1; rd_addr = a; arr_data = arr;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        rd_req = 1'b0; arr_data = 8'hEE;
    endtask

    // Monitor: compare each returned byte with the scoreboard head
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R9: unexpected rd_valid, actual 1 expected 0");
            end else begin
                automatic logic [7:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                check(t, rd_data, e);
            end
        end
    end

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 mode after reset", mode, 0);
        check("R1 rd_valid after reset", rd_valid, 0);
        rst_n = 1'b1;

        // Array pass-through
        rd(12'h123, 8'h9A, 8'h9A, "R9 array read a");
        rd(12'h010, 8'h17, 8'h17, "R9 array read b");

        // Partial address match is rejected
        wr(12'h855, 8'h98);
        check("R2 98h at 855h ignored", mode, 0);
        wr(12'h055, 8'h98);
        check("R2 query entry from array", mode, 2);

        for (int a = 'h10; a <= 'h1A; a++) begin
            rd(AW'(a), 8'hEE, query_byte(AW'(a)), (a <= 'h13 || a == 'h15) ? "R7 table" : "R8 table zero");
        end
        rd(12'h00F, 8'hEE, 8'h00, "R8 below table");
        rd(12'h01B, 8'hEE, 8'h00, "R8 above table");
        rd(12'h810, 8'hEE, 8'h00, "R8 high alias");

        // Non-reset writes in query are ignored
        wr(12'h555, 8'hAA);
        wr(12'h055, 8'h98);
        check("R6 write ignored in query", mode, 2);
        rd(12'h012, 8'hEE, 8'h59, "R6 table unchanged");

        wr(12'h3FF, 8'hF0);
        check("R5 exit to array", mode, 0);

        // Autoselect entry
        wr(12'h555, 8'hAA); wr(12'h2AA, 8'h55); wr(12'h555, 8'h90);
        check("R3 autoselect entry", mode, 1);
        rd(12'h000, 8'h11, AUTO_ID, "R10 autoselect id a");
        rd(12'h7AB, 8'h22, AUTO_ID, "R10 autoselect id b");

        wr(12'h055, 8'h98);
        check("R4 query from autoselect", mode, 2);
        rd(12'h010, 8'hEE, 8'h51, "R7 table via autoselect");
        wr(12'h000, 8'hF0);
        check("R5 exit back to autoselect", mode, 1);
        wr(12'h000, 8'hF0);
        check("R5 autoselect to array", mode, 0);

        // Broken unlock sequence
        wr(12'h555, 8'hAA); wr(12'h2AB, 8'h55); wr(12'h555, 8'h90);
        check("R3 aborted unlock", mode, 0);
        rd(12'h044, 8'h66, 8'h66, "R3 array after abort");

        // Abort input
        wr(12'h055, 8'h98);
        check("R11 setup query", mode, 2);
        @(negedge clk); force_array = 1'b1;
        @(negedge clk); force_array = 1'b0;
        check("R11 abort from query", mode, 0);
        @(negedge clk);
        force_array = 1'b1; wr_valid = 1'b1; wr_addr = 12'h055; wr_data = 8'h98;
        @(negedge clk);
        force_array = 1'b0; wr_valid = 1'b0;
        check("R11 abort beats write", mode, 0);

        repeat (4) @(negedge clk);
        check("R9 scoreboard drained", exp_q.size(), 0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule